// File: doc/BRIEF.md
# Processor trace status decoder

This block sits beside a processor and samples its two trace status buses on every clock: a 3-bit instruction status bus and a 2-bit history status bus. The 3-bit value means one of two things. After certain instruction kinds it is a count of instructions removed from the instruction queue. In every other slot it names the kind of instruction. The decoder tracks which meaning applies and emits one registered event per clock. It also follows the processor into and out of its debug (freeze) state and keeps running totals of both kinds of flush.

A programmable 8-bit mask selects which instruction-kind codes make the next slot a flush report. Bit n of the mask stands for code n. A flush slot that carries the not-taken branch code is reported as an instruction kind, because no legal flush count reaches seven. A reserved code in a flush slot is flagged as a protocol error.

Top module: `trace_status_decoder`

## Requirements
- R1: After reset every event output is 0, dbg_active_o and proto_err_sticky_o are 0, both totals are 0, the decoder expects an instruction-kind report and the mask holds MASK_RST (default 8'h30, which selects code 100 for exception taken and code 101 for indirect branch taken).
- R2: In an instruction-kind slot, itype_vld_o is 1 and itype_o carries the 3-bit code. The next slot is a flush slot exactly when mask bit [code] is 1.
- R3: In a flush slot, codes 000 to 101 give iq_flush_vld_o = 1 with iq_flush_cnt_o equal to the code, and the slot after it is an instruction-kind slot.
- R4: Code 111 in a flush slot gives itype_vld_o = 1 with itype_o = 111 (branch not taken), iq_flush_vld_o = 0, and the next slot follows mask bit 7.
- R5: Code 110 in a flush slot gives a one-cycle proto_err_o pulse and no other event. It sets proto_err_sticky_o, which stays set until reset, and the next slot is an instruction-kind slot.
- R6: Outside debug, history codes 00, 01 and 10 appear on hb_flush_cnt_o as 0, 1 and 2. Code 11 is never counted as a flush.
- R7: History code 11 outside debug gives a one-cycle dbg_enter_o pulse and sets dbg_active_o.
- R8: While dbg_active_o is 1, itype_vld_o, iq_flush_vld_o, proto_err_o and hb_flush_cnt_o are 0, and neither total changes.
- R9: The first slot in debug whose history code is not 11 clears dbg_active_o, pulses dbg_exit_o and is decoded as an instruction-kind slot. tsync_chg_o is 1 in that cycle exactly when tsync_i changed at any time after the entry cycle, up to and including the exit slot.
- R10: A write with mask_we_i = 1 loads mask_wdata_i into the mask. The new mask governs slots from the next clock on.
- R11: iq_total_o and hb_total_o add each reported flush count and saturate at all ones. cnt_clr_i zeroes both totals and takes priority over a flush in the same cycle.
- R12: Every output reflects the inputs sampled at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_i | input | 3 | Instruction status bus |
| hist_i | input | 2 | History status bus |
| tsync_i | input | 1 | Trace-sync level from the processor |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| cnt_clr_i | input | 1 | Synchronous clear of both totals |
| itype_vld_o | output | 1 | Instruction-kind event |
| itype_o | output | 3 | Instruction-kind code |
| iq_flush_vld_o | output | 1 | Queue-flush event |
| iq_flush_cnt_o | output | 3 | Instructions flushed from the instruction queue |
| hb_flush_cnt_o | output | 2 | Instructions flushed from the history buffer |
| dbg_enter_o | output | 1 | Debug entry pulse |
| dbg_active_o | output | 1 | Processor is in debug |
| dbg_exit_o | output | 1 | Debug exit pulse |
| tsync_chg_o | output | 1 | Trace-sync changed during debug (valid with dbg_exit_o) |
| proto_err_o | output | 1 | Reserved flush code seen |
| proto_err_sticky_o | output | 1 | Sticky protocol error |
| iq_total_o | output | CNT_W | Total of instruction-queue flushes |
| hb_total_o | output | CNT_W | Total of history-buffer flushes |

## Verification
The hardest states to reach are the two saturation boundaries of the totals. The bench clears the totals and then runs tens of thousands of history code 10 slots and alternating branch/flush-five pairs. This lands exactly one step below the maximum, then on it, then past it. The debug exit is also delicate: the trace-sync flag depends on activity spread over several frozen cycles. The bench scripts one exit with tsync_i held steady and one with a toggle in the middle of the freeze, and checks that the frozen cycles do not move the totals.

// File: rtl/trace_dec_pkg.sv
package trace_dec_pkg;

   localparam int ST_W   = 3;
   localparam int HIST_W = 2;

   localparam logic [HIST_W-1:0] HIST_FREEZE  = 2'b11;
   localparam logic [ST_W-1:0]   ST_NOT_TAKEN = 3'b111;
   localparam logic [ST_W-1:0]   ST_RSVD      = 3'b110;
   localparam logic [ST_W-1:0]   ST_MAX_FLUSH = 3'b101;

   typedef enum logic {
      EXP_TYPE  = 1'b0,
      EXP_FLUSH = 1'b1
   } tsd_mode_e;

   typedef struct packed {
      logic              itype_vld;
      logic [ST_W-1:0]   itype;
      logic              iq_vld;
      logic [ST_W-1:0]   iq_cnt;
      logic [HIST_W-1:0] hb_cnt;
      logic              dbg_enter;
      logic              dbg_exit;
      logic              tsync_chg;
      logic              err;
   } tsd_evt_t;

endpackage

// File: rtl/tsd_sat_counter.sv
module tsd_sat_counter #(
   parameter int W        = 16,
   parameter int INC_W    = 3,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [INC_W-1:0] inc_i,
   output logic [W-1:0]     cnt_o
);

   localparam int SUM_W = W + 1;

   logic [SUM_W-1:0] sum;
   logic [W-1:0]     cnt_n;

   initial begin : p_param_chk
      assert (INC_W < W) else $fatal(1, "tsd_sat_counter: INC_W must be below W");
   end

   assign sum = {1'b0, cnt_o} + {{(SUM_W-INC_W){1'b0}}, inc_i};

   generate
      if (SATURATE) begin : g_sat
         assign cnt_n = sum[W] ? {W{1'b1}} : sum[W-1:0];
      end else begin : g_wrap
         assign cnt_n = sum[W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) cnt_o <= '0;
      else                 cnt_o <= cnt_n;
   end

endmodule

// File: rtl/tsd_decode.sv
module tsd_decode
   import trace_dec_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ST_W-1:0]   stat_i,
   input  logic [HIST_W-1:0] hist_i,
   input  logic              tsync_i,
   input  logic [7:0]        mask_i,
   output tsd_evt_t          evt_d_o,
   output tsd_evt_t          evt_q_o,
   output logic              dbg_q_o,
   output logic              sticky_o
);

   tsd_mode_e mode_q, mode_n;
   logic      dbg_n;
   logic      chg_q, chg_n;
   logic      tsync_q;
   logic      tsync_edge;
   tsd_evt_t  nxt;

   assign tsync_edge = tsync_i ^ tsync_q;

   always_comb begin
      nxt    = '0;
      mode_n = mode_q;
      dbg_n  = dbg_q_o;
      chg_n  = chg_q;
      if (dbg_q_o) begin
         if (hist_i == HIST_FREEZE) begin
            chg_n = chg_q | tsync_edge;
         end else begin
            dbg_n         = 1'b0;
            chg_n         = 1'b0;
            nxt.dbg_exit  = 1'b1;
            nxt.tsync_chg = chg_q | tsync_edge;
            nxt.itype_vld = 1'b1;
            nxt.itype     = stat_i;
            nxt.hb_cnt    = hist_i;
            mode_n        = mask_i[stat_i] ? EXP_FLUSH : EXP_TYPE;
         end
      end else if (hist_i == HIST_FREEZE) begin
         dbg_n         = 1'b1;
         chg_n         = 1'b0;
         nxt.dbg_enter = 1'b1;
         mode_n        = EXP_TYPE;
      end else begin
         nxt.hb_cnt = hist_i;
         if (mode_q == EXP_TYPE) begin
            nxt.itype_vld = 1'b1;
            nxt.itype     = stat_i;
            mode_n        = mask_i[stat_i] ? EXP_FLUSH : EXP_TYPE;
         end else if (stat_i <= ST_MAX_FLUSH) begin
            nxt.iq_vld = 1'b1;
            nxt.iq_cnt = stat_i;
            mode_n     = EXP_TYPE;
         end else if (stat_i == ST_NOT_TAKEN) begin
            nxt.itype_vld = 1'b1;
            nxt.itype     = stat_i;
            mode_n        = mask_i[ST_NOT_TAKEN] ? EXP_FLUSH : EXP_TYPE;
         end else begin
            nxt.err = 1'b1;
            mode_n  = EXP_TYPE;
         end
      end
   end

   assign evt_d_o = nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= EXP_TYPE;
         dbg_q_o  <= 1'b0;
         chg_q    <= 1'b0;
         tsync_q  <= 1'b0;
         evt_q_o  <= '0;
         sticky_o <= 1'b0;
      end else begin
         mode_q   <= mode_n;
         dbg_q_o  <= dbg_n;
         chg_q    <= chg_n;
         tsync_q  <= tsync_i;
         evt_q_o  <= nxt;
         sticky_o <= sticky_o | nxt.err;
      end
   end

endmodule

// File: rtl/trace_status_decoder.sv
module trace_status_decoder
   import trace_dec_pkg::*;
#(
   parameter int         CNT_W    = 16,
   parameter logic [7:0] MASK_RST = 8'h30,
   parameter bit         SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       stat_i,
   input  logic [1:0]       hist_i,
   input  logic             tsync_i,
   input  logic             mask_we_i,
   input  logic [7:0]       mask_wdata_i,
   input  logic             cnt_clr_i,
   output logic             itype_vld_o,
   output logic [2:0]       itype_o,
   output logic             iq_flush_vld_o,
   output logic [2:0]       iq_flush_cnt_o,
   output logic [1:0]       hb_flush_cnt_o,
   output logic             dbg_enter_o,
   output logic             dbg_active_o,
   output logic             dbg_exit_o,
   output logic             tsync_chg_o,
   output logic             proto_err_o,
   output logic             proto_err_sticky_o,
   output logic [CNT_W-1:0] iq_total_o,
   output logic [CNT_W-1:0] hb_total_o
);

   localparam int N_CNT = 2;

   logic [7:0] mask_q;
   tsd_evt_t   evt_d, evt_q;
   logic [ST_W-1:0] inc [N_CNT];
   logic [CNT_W-1:0] tot [N_CNT];

   initial begin : p_param_chk
      assert (CNT_W > ST_W) else $fatal(1, "trace_status_decoder: CNT_W too small");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         mask_q <= MASK_RST;
      else if (mask_we_i) mask_q <= mask_wdata_i;
   end

   tsd_decode u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .stat_i   (stat_i),
      .hist_i   (hist_i),
      .tsync_i  (tsync_i),
      .mask_i   (mask_q),
      .evt_d_o  (evt_d),
      .evt_q_o  (evt_q),
      .dbg_q_o  (dbg_active_o),
      .sticky_o (proto_err_sticky_o)
   );

   assign inc[0] = evt_d.iq_cnt;
   assign inc[1] = {1'b0, evt_d.hb_cnt};

   generate
      for (genvar i = 0; i < N_CNT; i++) begin : g_tot
         tsd_sat_counter #(
            .W        (CNT_W),
            .INC_W    (ST_W),
            .SATURATE (SATURATE)
         ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (cnt_clr_i),
            .inc_i (inc[i]),
            .cnt_o (tot[i])
         );
      end
   endgenerate

   assign iq_total_o     = tot[0];
   assign hb_total_o     = tot[1];
   assign itype_vld_o    = evt_q.itype_vld;
   assign itype_o        = evt_q.itype;
   assign iq_flush_vld_o = evt_q.iq_vld;
   assign iq_flush_cnt_o = evt_q.iq_cnt;
   assign hb_flush_cnt_o = evt_q.hb_cnt;
   assign dbg_enter_o    = evt_q.dbg_enter;
   assign dbg_exit_o     = evt_q.dbg_exit;
   assign tsync_chg_o    = evt_q.tsync_chg;
   assign proto_err_o    = evt_q.err;

endmodule

// File: rtl/trace_status_decoder_chk.sv
module trace_status_decoder_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       hist_i,
   input logic             cnt_clr_i,
   input logic             itype_vld_o,
   input logic             iq_flush_vld_o,
   input logic [2:0]       iq_flush_cnt_o,
   input logic [1:0]       hb_flush_cnt_o,
   input logic             dbg_enter_o,
   input logic             dbg_active_o,
   input logic             dbg_exit_o,
   input logic             proto_err_o,
   input logic             proto_err_sticky_o,
   input logic [CNT_W-1:0] iq_total_o,
   input logic [CNT_W-1:0] hb_total_o
);

   assert_flush_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      iq_flush_vld_o |-> (iq_flush_cnt_o <= 3'd5));

   assert_one_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({itype_vld_o, iq_flush_vld_o, proto_err_o}) <= 1);

   assert_err_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err_sticky_o |=> proto_err_sticky_o);

   assert_err_sets_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err_o |-> proto_err_sticky_o);

   assert_freeze_not_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_i == 2'b11 && !cnt_clr_i) |=> (hb_total_o == $past(hb_total_o)));

   assert_enter_sets_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_enter_o |-> dbg_active_o);

   assert_silent_in_debug_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_active_o |-> (!itype_vld_o && !iq_flush_vld_o && !proto_err_o && hb_flush_cnt_o == 2'b00));

   assert_exit_after_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_exit_o |-> (!dbg_active_o && $past(dbg_active_o) && itype_vld_o));

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (iq_total_o == {CNT_W{1'b1}} && !cnt_clr_i) |=> (iq_total_o == {CNT_W{1'b1}}));

   assert_hb_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_total_o == {CNT_W{1'b1}} && !cnt_clr_i) |=> (hb_total_o == {CNT_W{1'b1}}));

endmodule

bind trace_status_decoder trace_status_decoder_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/trace_status_decoder_tb.sv
`timescale 1ns/1ps
module trace_status_decoder_tb;

   localparam int CNT_W = 16;
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [2:0]       stat_i = '0;
   logic [1:0]       hist_i = '0;
   logic             tsync_i = 1'b0;
   logic             mask_we_i = 1'b0;
   logic [7:0]       mask_wdata_i = '0;
   logic             cnt_clr_i = 1'b0;
   logic             itype_vld_o;
   logic [2:0]       itype_o;
   logic             iq_flush_vld_o;
   logic [2:0]       iq_flush_cnt_o;
   logic [1:0]       hb_flush_cnt_o;
   logic             dbg_enter_o;
   logic             dbg_active_o;
   logic             dbg_exit_o;
   logic             tsync_chg_o;
   logic             proto_err_o;
   logic             proto_err_sticky_o;
   logic [CNT_W-1:0] iq_total_o;
   logic [CNT_W-1:0] hb_total_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   trace_status_decoder #(.CNT_W(CNT_W)) u_dut (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Inputs change at the falling edge; outputs are sampled 1 ns after the
   // rising edge that registered them (R12: one cycle of latency).
   task automatic step(input logic [2:0] s, input logic [1:0] h);
      @(negedge clk);
      stat_i = s;
      hist_i = h;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      check("R1 itype_vld", itype_vld_o, 0);
      check("R1 flush_vld", iq_flush_vld_o, 0);
      check("R1 dbg_active", dbg_active_o, 0);
      check("R1 sticky", proto_err_sticky_o, 0);
      check("R1 totals", {iq_total_o, hb_total_o}, 0);
   endtask

   task automatic t_type_decode;
      step(3'b010, 2'b00);
      check("R12 R2 itype_vld", itype_vld_o, 1);
      check("R2 itype 010", itype_o, 3'b010);
      step(3'b011, 2'b01);
      check("R2 itype 011 stays type", {itype_vld_o, itype_o, iq_flush_vld_o}, {1'b1, 3'b011, 1'b0});
      check("R6 hist 01", hb_flush_cnt_o, 1);
   endtask

   task automatic t_flush;
      step(3'b101, 2'b00);
      check("R2 branch taken", {itype_vld_o, itype_o}, {1'b1, 3'b101});
      step(3'b011, 2'b10);
      check("R3 flush 3", {iq_flush_vld_o, iq_flush_cnt_o, itype_vld_o}, {1'b1, 3'd3, 1'b0});
      check("R6 hist 10", hb_flush_cnt_o, 2);
      step(3'b001, 2'b00);
      check("R3 back to type", {itype_vld_o, itype_o, iq_flush_vld_o}, {1'b1, 3'b001, 1'b0});
      step(3'b100, 2'b00);
      step(3'b101, 2'b00);
      check("R3 flush 5", {iq_flush_vld_o, iq_flush_cnt_o}, {1'b1, 3'd5});
      step(3'b101, 2'b00);
      step(3'b000, 2'b00);
      check("R3 flush 0", {iq_flush_vld_o, iq_flush_cnt_o, itype_vld_o}, {1'b1, 3'd0, 1'b0});
   endtask

   task automatic t_not_taken;
      step(3'b100, 2'b00);
      step(3'b111, 2'b00);
      check("R4 not taken", {itype_vld_o, itype_o, iq_flush_vld_o}, {1'b1, 3'b111, 1'b0});
      step(3'b010, 2'b00);
      check("R4 next slot is type", {itype_vld_o, itype_o}, {1'b1, 3'b010});
   endtask

   task automatic t_reserved;
      step(3'b101, 2'b00);
      step(3'b110, 2'b00);
      check("R5 error pulse", {proto_err_o, proto_err_sticky_o, itype_vld_o, iq_flush_vld_o}, 4'b1100);
      step(3'b010, 2'b00);
      check("R5 pulse ends, sticky holds, type", {proto_err_o, proto_err_sticky_o, itype_vld_o, itype_o}, {1'b0, 1'b1, 1'b1, 3'b010});
   endtask

   task automatic t_debug_plain;
      logic [CNT_W-1:0] hb0;
      step(3'b100, 2'b00);
      hb0 = hb_total_o;
      step(3'b000, 2'b11);
      check("R7 enter", {dbg_enter_o, dbg_active_o, itype_vld_o}, 3'b110);
      step(3'b000, 2'b11);
      check("R8 silent", {dbg_enter_o, dbg_active_o, itype_vld_o, iq_flush_vld_o, hb_flush_cnt_o}, 6'b010000);
      step(3'b000, 2'b11);
      check("R6 freeze not counted", hb_total_o, hb0);
      step(3'b101, 2'b00);
      check("R9 exit no sync change", {dbg_exit_o, dbg_active_o, tsync_chg_o, itype_vld_o, itype_o}, {1'b1, 1'b0, 1'b0, 1'b1, 3'b101});
      step(3'b010, 2'b01);
      check("R9 exit code drives flush slot", {iq_flush_vld_o, iq_flush_cnt_o}, {1'b1, 3'd2});
   endtask

   task automatic t_debug_sync;
      step(3'b100, 2'b00);
      step(3'b000, 2'b11);
      tsync_i = 1'b1;
      step(3'b000, 2'b11);
      step(3'b000, 2'b11);
      step(3'b010, 2'b00);
      check("R9 exit with sync change", {dbg_exit_o, tsync_chg_o, itype_vld_o, itype_o}, {1'b1, 1'b1, 1'b1, 3'b010});
      step(3'b011, 2'b00);
      check("R9 flag is one cycle", {dbg_exit_o, tsync_chg_o, itype_o}, {1'b0, 1'b0, 3'b011});
   endtask

   task automatic t_mask;
      @(negedge clk);
      mask_we_i    = 1'b1;
      mask_wdata_i = 8'h04;
      step(3'b000, 2'b00);
      mask_we_i = 1'b0;
      step(3'b010, 2'b00);
      step(3'b011, 2'b00);
      check("R10 new mask selects code 010", {iq_flush_vld_o, iq_flush_cnt_o}, {1'b1, 3'd3});
      step(3'b101, 2'b00);
      step(3'b001, 2'b00);
      check("R10 code 101 no longer selects", {itype_vld_o, itype_o}, {1'b1, 3'b001});
      @(negedge clk);
      mask_we_i    = 1'b1;
      mask_wdata_i = 8'h30;
      step(3'b000, 2'b00);
      mask_we_i = 1'b0;
   endtask

   task automatic t_counters;
      @(negedge clk);
      cnt_clr_i = 1'b1;
      step(3'b000, 2'b00);
      cnt_clr_i = 1'b0;
      check("R11 clear", {iq_total_o, hb_total_o}, 0);
      step(3'b101, 2'b01);
      step(3'b100, 2'b10);
      check("R11 iq sum", iq_total_o, 4);
      check("R11 hb sum", hb_total_o, 3);
      step(3'b101, 2'b00);
      @(negedge clk);
      cnt_clr_i = 1'b1;
      step(3'b011, 2'b01);
      cnt_clr_i = 1'b0;
      check("R11 clear beats flush", {iq_total_o, hb_total_o}, 0);
      for (int i = 0; i < 32767; i++) step(3'b010, 2'b10);
      check("R11 hb below max", hb_total_o, MAXV - 1);
      step(3'b010, 2'b10);
      check("R11 hb at max", hb_total_o, MAXV);
      step(3'b010, 2'b10);
      check("R11 hb saturates", hb_total_o, MAXV);
      for (int i = 0; i < 13107; i++) begin
         step(3'b101, 2'b00);
         step(3'b101, 2'b00);
      end
      check("R11 iq at max", iq_total_o, MAXV);
      step(3'b101, 2'b00);
      step(3'b101, 2'b00);
      check("R11 iq saturates", iq_total_o, MAXV);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_type_decode();
      t_flush();
      t_not_taken();
      t_reserved();
      t_debug_plain();
      t_debug_sync();
      t_mask();
      t_counters();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule